// File: doc/BRIEF.md
# Asynchronous Register Update Bridge

This block sits between a register interface on the main clock and a timer core that can be clocked either by the main clock or by a slow external oscillator. It covers three writable timer registers: the counter load, the compare value and the control word. In main-clock mode a write reaches the timer side on the next main clock edge. In slow-clock mode a write is parked in a holding register for that register alone, and the register's busy flag is raised. The value is then committed into the slow domain. The busy flag drops only when an acknowledge from the slow domain has crossed back through a synchronizer.

Each register has its own holding register, request toggle and acknowledge path. A pending write to one register therefore never delays or disturbs a write to another. A write aimed at a register that is still busy is discarded and raises a sticky error bit. While a counter or compare write is in flight, the compare function of the timer is held off. Any change of the clock-select input returns the bridge to an idle state.

Top module: `async_reg_bridge`

## Requirements
- R1: With `useSlowClk` low, a write is accepted on the clock edge that samples it and shows on the timer outputs after that same edge. `busy` stays 0. A counter write drives `cntLoad` high for exactly one main clock cycle, with the written value on `cntLoadVal`.
- R2: With `useSlowClk` high, an accepted write sets the busy bit of the addressed register on the sampling edge. The register select encoding is 0 for counter, 1 for compare and 2 for control, and busy bit i belongs to select value i.
- R3: In slow-clock mode, a written value reaches the timer outputs on the second rising edge of `slowClk` after the write edge. It is not visible after the first such edge. Each counter write gives exactly one `cntLoad` pulse on the slow side.
- R4: A busy bit stays set after the value has landed on the slow side. It clears on the third main clock edge after the landing edge, once the acknowledge has passed two synchronizing flops.
- R5: Writes to different registers issued on consecutive cycles are all accepted, are pending together, and each lands with its own value.
- R6: `rdData` returns the live `liveCount` input for select 0, the holding register for select 1 or 2, and zero for select 3.
- R7: `cmpEnable` is low whenever the counter or compare busy bit is set, and high otherwise.
- R8: A write to a register whose busy bit is set is discarded, so the holding and landed values keep the earlier write. It sets `wrErr`, which then stays set until reset.
- R9: In the cycle after `useSlowClk` changes, every holding register reads zero and all busy bits are clear. A write sampled on the edge of the change is discarded.
- R10: After reset, busy bits, `wrErr`, all holding registers and the main-mode timer outputs are zero, and `cmpEnable` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| slowClk | input | 1 | Slow oscillator clock, at least four times slower than clk |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| useSlowClk | input | 1 | Clock select: 0 main clock, 1 slow clock |
| wrEn | input | 1 | Write strobe |
| wrSel | input | 2 | Write target: 0 counter, 1 compare, 2 control |
| wrData | input | W | Write data |
| rdSel | input | 2 | Read target, same encoding as wrSel |
| rdData | output | W | Read data |
| liveCount | input | W | Running counter value from the timer core |
| busy | output | 3 | Per-register update busy flags |
| wrErr | output | 1 | Sticky flag for writes discarded because the target was busy |
| cmpEnable | output | 1 | Compare function permitted |
| cntLoad | output | 1 | One-cycle counter load pulse in the active timer clock domain |
| cntLoadVal | output | W | Counter load value |
| cmpValue | output | W | Compare value seen by the timer |
| ctrlValue | output | W | Control word seen by the timer |

## Verification
Two events can fall on the same main clock edge: a change of the clock select and a write. The bench drives both together. It then judges that the write left no trace: the holding register reads zero, no busy bit rose, and the main-mode output stays zero. The second overlap is a write to a register whose acknowledge is still in flight. The bench issues a second write right behind the first and expects the error flag to be set and the first value to land. A scoreboard queue holds each expected landing value, and a monitor compares that value with the timer output on every falling edge of a busy bit.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int NREG = 3;
  localparam int REG_CNT = 0;
  localparam int REG_CMP = 1;
  localparam int REG_CTL = 2;

  // strobes from control to datapath, main clock domain
  typedef struct packed {
    logic            mode;        // 1: timer runs from slow clock
    logic            clearAll;    // clock select changed
    logic [NREG-1:0] holdWr;      // accepted write per register
    logic            syncCntLoad; // counter write in main-clock mode
  } strobeT;
endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            useSlowClk,
  input  logic            wrEn,
  input  logic [1:0]      wrSel,
  input  logic [NREG-1:0] ackTgl,
  output logic [NREG-1:0] reqTgl,
  output logic [NREG-1:0] busy,
  output logic            wrErr,
  output logic            cmpEnable,
  output strobeT          stb
);
  logic            selQ;
  logic [NREG-1:0] ackS1, ackS2, busyQ, reqQ, hit, acc;
  logic            errQ, selChange, errHit;

  assign selChange = useSlowClk != selQ;

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      hit[i] = wrEn && (wrSel == 2'(i));
      acc[i] = hit[i] && !selChange && !busyQ[i];
    end
    errHit = wrEn && !selChange && |(hit & busyQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ  <= 1'b0;
      ackS1 <= '0;
      ackS2 <= '0;
      busyQ <= '0;
      reqQ  <= '0;
      errQ  <= 1'b0;
    end else begin
      selQ  <= useSlowClk;
      ackS1 <= ackTgl;
      ackS2 <= ackS1;
      if (errHit) errQ <= 1'b1;
      for (int i = 0; i < NREG; i++) begin
        if (selChange) begin
          busyQ[i] <= 1'b0;
        end else if (acc[i] && selQ) begin
          busyQ[i] <= 1'b1;
          reqQ[i]  <= ~reqQ[i];
        end else if (busyQ[i] && (ackS2[i] == reqQ[i])) begin
          busyQ[i] <= 1'b0;
        end
      end
    end
  end

  assign reqTgl    = reqQ;
  assign busy      = busyQ;
  assign wrErr     = errQ;
  assign cmpEnable = !(busyQ[REG_CNT] || busyQ[REG_CMP]);

  always_comb begin
    stb.mode        = selQ;
    stb.clearAll    = selChange;
    stb.holdWr      = acc;
    stb.syncCntLoad = acc[REG_CNT] && !selQ;
  end

  for (genvar g = 0; g < NREG; g++) begin : gChk
    assert_busy_set_R2: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && wrSel == 2'(g) && !busyQ[g] && selQ && useSlowClk) |=> busyQ[g]);
    assert_busy_wait_ack_R4: assert property (@(posedge clk) disable iff (!rstN)
      (busyQ[g] && ackS2[g] != reqQ[g] && useSlowClk == selQ) |=> busyQ[g]);
  end

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    errQ |=> errQ);
  assert_main_mode_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    !selQ |-> busyQ == '0);
  assert_change_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    selChange |=> busyQ == '0);
endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int W = 8
) (
  input  logic            clk,
  input  logic            slowClk,
  input  logic            rstN,
  input  strobeT          stb,
  input  logic [W-1:0]    wrData,
  input  logic [1:0]      rdSel,
  input  logic [W-1:0]    liveCount,
  input  logic [NREG-1:0] reqTgl,
  output logic [NREG-1:0] ackTgl,
  output logic [W-1:0]    rdData,
  output logic            cntLoad,
  output logic [W-1:0]    cntLoadVal,
  output logic [W-1:0]    cmpValue,
  output logic [W-1:0]    ctrlValue
);
  logic [W-1:0]    holdV [NREG];
  logic [W-1:0]    destV [NREG];
  logic [NREG-1:0] loadV;
  logic            mainLoadQ, slowLoadQ;

  for (genvar g = 0; g < NREG; g++) begin : gReg
    logic [W-1:0] holdQ, destQ;
    logic         reqS1, reqS2;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                holdQ <= '0;
      else if (stb.clearAll)    holdQ <= '0;
      else if (stb.holdWr[g])   holdQ <= wrData;
    end

    // slow side: first stage samples the toggle, commit on the second edge
    always_ff @(posedge slowClk or negedge rstN) begin
      if (!rstN) begin
        reqS1 <= 1'b0;
        reqS2 <= 1'b0;
        destQ <= '0;
      end else begin
        reqS1 <= reqTgl[g];
        reqS2 <= reqS1;
        if (reqS1 != reqS2) destQ <= holdQ;
      end
    end

    assign holdV[g]  = holdQ;
    assign destV[g]  = destQ;
    assign loadV[g]  = reqS1 != reqS2;
    assign ackTgl[g] = reqS2;

    assert_hold_cleared_R9: assert property (@(posedge clk) disable iff (!rstN)
      stb.clearAll |=> holdQ == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mainLoadQ <= 1'b0;
    else       mainLoadQ <= stb.syncCntLoad;
  end

  always_ff @(posedge slowClk or negedge rstN) begin
    if (!rstN) slowLoadQ <= 1'b0;
    else       slowLoadQ <= loadV[REG_CNT];
  end

  assign cntLoad    = stb.mode ? slowLoadQ       : mainLoadQ;
  assign cntLoadVal = stb.mode ? destV[REG_CNT]  : holdV[REG_CNT];
  assign cmpValue   = stb.mode ? destV[REG_CMP]  : holdV[REG_CMP];
  assign ctrlValue  = stb.mode ? destV[REG_CTL]  : holdV[REG_CTL];

  always_comb begin
    case (rdSel)
      2'd0:    rdData = liveCount;
      2'd1:    rdData = holdV[REG_CMP];
      2'd2:    rdData = holdV[REG_CTL];
      default: rdData = '0;
    endcase
  end

  assert_main_pulse_one_cycle_R1: assert property (@(posedge clk) disable iff (!rstN)
    mainLoadQ |=> !mainLoadQ);
endmodule

// File: rtl/async_reg_bridge.sv
module async_reg_bridge
  import arb_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         slowClk,
  input  logic         rstN,
  input  logic         useSlowClk,
  input  logic         wrEn,
  input  logic [1:0]   wrSel,
  input  logic [W-1:0] wrData,
  input  logic [1:0]   rdSel,
  output logic [W-1:0] rdData,
  input  logic [W-1:0] liveCount,
  output logic [2:0]   busy,
  output logic         wrErr,
  output logic         cmpEnable,
  output logic         cntLoad,
  output logic [W-1:0] cntLoadVal,
  output logic [W-1:0] cmpValue,
  output logic [W-1:0] ctrlValue
);
  strobeT          stb;
  logic [NREG-1:0] reqTgl, ackTgl;

  arb_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .useSlowClk(useSlowClk), .wrEn(wrEn), .wrSel(wrSel),
    .ackTgl(ackTgl), .reqTgl(reqTgl), .busy(busy), .wrErr(wrErr),
    .cmpEnable(cmpEnable), .stb(stb)
  );

  arb_datapath #(.W(W)) uData (
    .clk(clk), .slowClk(slowClk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .rdSel(rdSel), .liveCount(liveCount), .reqTgl(reqTgl), .ackTgl(ackTgl),
    .rdData(rdData), .cntLoad(cntLoad), .cntLoadVal(cntLoadVal),
    .cmpValue(cmpValue), .ctrlValue(ctrlValue)
  );
endmodule

// File: tb/async_reg_bridge_test.sv
module async_reg_bridge_test;
  localparam int CLK_PERIOD = 10;
  localparam int SLOW_HALF  = 26;
  localparam int W = 8;

  logic clk = 0, slowClk = 0, rstN = 0, useSlowClk = 0, wrEn = 0;
  logic [1:0] wrSel = 0, rdSel = 0;
  logic [W-1:0] wrData = 0, liveCount = 0;
  logic [W-1:0] rdData, cntLoadVal, cmpValue, ctrlValue;
  logic [2:0] busy, prevBusy = 0;
  logic wrErr, cmpEnable, cntLoad;
  logic monOn = 1;
  int nChecks = 0, nFails = 0, slowPulses = 0, cyc;
  logic [W-1:0] q0[$], q1[$], q2[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(SLOW_HALF) slowClk = ~slowClk;

  async_reg_bridge #(.W(W)) uut (
    .clk(clk), .slowClk(slowClk), .rstN(rstN), .useSlowClk(useSlowClk),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .rdSel(rdSel), .rdData(rdData),
    .liveCount(liveCount), .busy(busy), .wrErr(wrErr), .cmpEnable(cmpEnable),
    .cntLoad(cntLoad), .cntLoadVal(cntLoadVal), .cmpValue(cmpValue),
    .ctrlValue(ctrlValue)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [W-1:0] d, input bit push);
    @(negedge clk);
    wrEn = 1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 0;
    if (push) begin
      if (sel == 0) q0.push_back(d);
      else if (sel == 1) q1.push_back(d);
      else q2.push_back(d);
    end
  endtask

  task automatic waitIdle(input int idx, output int n);
    n = 0;
    while (busy[idx] && n < 50) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  endtask

  // scoreboard monitor: each busy fall must expose the queued value
  always @(negedge clk) begin
    if (rstN && monOn) begin
      for (int i = 0; i < 3; i++) begin
        if (prevBusy[i] && !busy[i]) begin
          logic [W-1:0] exp, act;
          bit have;
          act = (i == 0) ? cntLoadVal : (i == 1) ? cmpValue : ctrlValue;
          have = (i == 0) ? q0.size() > 0 : (i == 1) ? q1.size() > 0 : q2.size() > 0;
          if (have) begin
            exp = (i == 0) ? q0.pop_front() : (i == 1) ? q1.pop_front() : q2.pop_front();
            check(act == exp, "R5 scoreboard landed value", act, exp);
          end else begin
            check(0, "R5 busy fell with nothing queued", act, 0);
          end
        end
      end
    end
    prevBusy <= busy;
  end

  always @(negedge slowClk) if (cntLoad && useSlowClk) slowPulses++;

  initial begin
    #(CLK_PERIOD * 100000);
    check(0, "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    rdSel = 1; #1;
    check(busy == 0, "R10 busy after reset", busy, 0);
    check(wrErr == 0, "R10 wrErr after reset", wrErr, 0);
    check(cmpEnable == 1, "R10 cmpEnable after reset", cmpEnable, 1);
    check(rdData == 0, "R10 compare hold after reset", rdData, 0);
    check(cmpValue == 0, "R10 cmpValue after reset", cmpValue, 0);

    // main-clock mode
    wr(1, 8'h5A, 0); #1;
    check(busy == 0, "R1 no busy in main mode", busy, 0);
    check(cmpValue == 8'h5A, "R1 compare applied", cmpValue, 8'h5A);
    check(rdData == 8'h5A, "R6 compare read hold", rdData, 8'h5A);
    wr(0, 8'h33, 0); #1;
    check(cntLoad == 1, "R1 load pulse", cntLoad, 1);
    check(cntLoadVal == 8'h33, "R1 load value", cntLoadVal, 8'h33);
    @(negedge clk); #1;
    check(cntLoad == 0, "R1 load pulse ends", cntLoad, 0);

    liveCount = 8'h77; rdSel = 0; #1;
    check(rdData == 8'h77, "R6 live counter read", rdData, 8'h77);
    rdSel = 3; #1;
    check(rdData == 0, "R6 unused select", rdData, 0);

    // switch to slow clock
    useSlowClk = 1;
    @(negedge clk); @(negedge clk);
    rdSel = 1; #1;
    check(rdData == 0, "R9 hold cleared on select change", rdData, 0);

    // two-edge landing
    @(posedge slowClk);
    wr(1, 8'hA5, 1); #1;
    check(busy[1] == 1, "R2 busy set", busy, 3'b010);
    check(rdData == 8'hA5, "R6 read returns hold", rdData, 8'hA5);
    check(cmpEnable == 0, "R7 compare held off", cmpEnable, 0);
    @(posedge slowClk); #1;
    check(cmpValue == 0, "R3 not landed after first edge", cmpValue, 0);
    @(posedge slowClk); #1;
    check(cmpValue == 8'hA5, "R3 landed after second edge", cmpValue, 8'hA5);
    check(busy[1] == 1, "R4 busy held until ack", busy[1], 1);
    waitIdle(1, cyc);
    check(cyc >= 2 && cyc <= 4, "R4 ack latency in main cycles", cyc, 3);
    check(cmpEnable == 1, "R7 compare re-enabled", cmpEnable, 1);

    // independent registers
    wr(0, 8'h10, 1); wr(1, 8'h20, 1); wr(2, 8'h30, 1); #1;
    check(busy == 3'b111, "R5 three writes pending", busy, 3'b111);
    check(cmpEnable == 0, "R7 held off by counter and compare", cmpEnable, 0);
    for (int i = 0; i < 3; i++) waitIdle(i, cyc);
    @(negedge clk); @(negedge clk);
    check(q0.size() + q1.size() + q2.size() == 0, "R5 all writes landed",
          q0.size() + q1.size() + q2.size(), 0);
    check(ctrlValue == 8'h30, "R5 control landed", ctrlValue, 8'h30);
    check(slowPulses == 1, "R3 one slow load pulse", slowPulses, 1);

    // write while busy
    wr(1, 8'h11, 1); wr(1, 8'h22, 0); #1;
    rdSel = 1; #1;
    check(wrErr == 1, "R8 error raised", wrErr, 1);
    check(rdData == 8'h11, "R8 hold keeps first write", rdData, 8'h11);
    waitIdle(1, cyc);
    @(negedge clk); #1;
    check(cmpValue == 8'h11, "R8 first write landed", cmpValue, 8'h11);
    check(wrErr == 1, "R8 error sticky", wrErr, 1);

    // select change colliding with a write
    @(negedge clk);
    useSlowClk = 0; wrEn = 1; wrSel = 1; wrData = 8'h44;
    @(negedge clk);
    wrEn = 0; #1;
    check(busy == 0, "R9 no busy after collision", busy, 0);
    check(rdData == 0, "R9 colliding write discarded", rdData, 0);
    check(cmpValue == 0, "R9 main output idle", cmpValue, 0);

    // select change while a write is pending
    useSlowClk = 1;
    @(negedge clk); @(negedge clk);
    wr(2, 8'h66, 0); #1;
    check(busy[2] == 1, "R2 control busy", busy[2], 1);
    monOn = 0; useSlowClk = 0;
    @(negedge clk); #1;
    rdSel = 2; #1;
    check(busy == 0, "R9 busy cleared by select change", busy, 0);
    check(rdData == 0, "R9 control hold cleared", rdData, 0);
    repeat (20) @(negedge clk);
    monOn = 1;
    check(busy == 0, "R1 main mode stays idle", busy, 0);

    wr(2, 8'h9C, 0); #1;
    check(ctrlValue == 8'h9C, "R1 control applied", ctrlValue, 8'h9C);
    check(busy == 0, "R1 control no busy", busy, 0);

    finishRun();
  end
endmodule